// File: doc/BRIEF.md
# Integer Execute Stage with Shifted Immediates

This block is the combinational arithmetic and logic stage of a 32-bit load/store core. Each cycle it receives a 5-bit opcode that has already been split out of the instruction word, the low 17 bits of that word (the immediate, mode and shift-amount fields), and the values of the two source registers read by the decode stage. It returns the value to be written back to the destination register, plus a write strobe that tells the register file whether this opcode writes at all.

Two immediate flavours exist. The plain flavour sign-extends a 17-bit constant. The shifted flavour sign-extends a 10-bit constant and passes it through one of four shift or rotate modes by a 5-bit amount before it reaches the adder or logic unit. This lets small patterns be placed anywhere in a word. The dedicated shift and rotate opcodes take their distance either from the instruction or from the low bits of the second register, and a single flag bit picks which.

Top module: `exec_unit`

## Requirements
- R1: Opcodes 0 through 18 drive `wrEn` high. Opcodes 19 through 31 drive `wrEn` low and `result` to zero.
- R2: Opcodes 0, 2 and 4 sign-extend `immField[16:0]` to 32 bits and add it to, OR it with, or AND it with `rbVal`, in that order.
- R3: Opcodes 1, 3, 5 and 7 sign-extend `immField[16:7]` and then transform it by the mode in `immField[6:5]` (00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right) over the distance `immField[4:0]`. Opcodes 1, 3 and 5 then add, OR or AND the outcome with `rbVal`.
- R4: Opcodes 6 (17-bit form) and 7 (shifted form) write the formed immediate itself, and `rbVal` has no effect on the result.
- R5: Opcode 8 gives `rbVal + rcVal` and opcode 9 gives `rbVal - rcVal`, both modulo 2^32 and with no overflow indication.
- R6: Opcode 10 gives the bitwise inverse of `rcVal` and opcode 11 its two's complement. `rbVal` has no effect on either.
- R7: Opcodes 12, 13 and 14 give the bitwise OR, AND and XOR of `rbVal` and `rcVal`.
- R8: Opcodes 15 (arithmetic right), 16 (logical right), 17 (left) and 18 (rotate right) act on `rbVal`. The distance is `immField[4:0]` when `immField[5]` is 0, and `rcVal[4:0]` when it is 1.
- R9: An arithmetic right shift fills vacated bits with bit 31 of its operand. Logical right and left shifts fill with zeros. A rotate right reinserts the bits leaving bit 0 at bit 31.
- R10: Any shift or rotate, register or immediate, with a distance of 0 returns its operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 5 | Decoded operation code |
| immField | input | 17 | Instruction bits 16..0: immediate, mode, flag and distance fields |
| rbVal | input | 32 | First source register value |
| rcVal | input | 32 | Second source register value |
| result | output | 32 | Value to write back |
| wrEn | output | 1 | Write-back strobe |

## Verification
Two shifters compute on every input: the one that shapes the 10-bit immediate and the one that moves the register operand. For a shift opcode, bits 16..5 still look like a valid shifted immediate, and for a shifted-immediate opcode, `rcVal` still carries a distance. The sweep always fills both with conflicting, non-trivial values, including a flag bit that aliases the low mode bit. Any leak of the idle shifter, or a wrong choice of distance source, shows up as a mismatch against the arithmetic model in the bench.

// File: rtl/exec_pkg.sv
package exec_pkg;

  typedef enum logic [1:0] {
    SH_LEFT   = 2'b00,
    SH_LRIGHT = 2'b01,
    SH_ARIGHT = 2'b10,
    SH_ROTR   = 2'b11
  } shiftKind_e;

  typedef enum logic [3:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_OR,
    ALU_AND,
    ALU_XOR,
    ALU_NOT,
    ALU_NEG,
    ALU_PASS,
    ALU_SHIFT
  } aluOp_e;

  typedef struct packed {
    logic       wrEn;
    aluOp_e     aluOp;
    logic       useImm;
    logic       immShifted;
    logic       shiftFromReg;
    shiftKind_e shiftKind;
  } ctrl_t;

  localparam int OPC_W        = 5;
  localparam int LAST_WRITING = 18;

endpackage

// File: rtl/exec_shifter.sv
module exec_shifter
  import exec_pkg::*;
#(
  parameter int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  shiftKind_e    kind,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic          isLeft;
  logic          isRot;
  logic          fillBit;
  logic [W-1:0]  revIn;
  logic [W-1:0]  stageIn;
  logic [W-1:0]  stageOut;
  logic [W-1:0]  revOut;
  logic [W-1:0]  stg [0:SW];

  assign isLeft  = (kind == SH_LEFT);
  assign isRot   = (kind == SH_ROTR);
  assign fillBit = (kind == SH_ARIGHT) ? din[W-1] : 1'b0;

  // Left shifts reuse the right-moving stages on a bit-reversed word.
  for (genvar gi = 0; gi < W; gi++) begin : g_rev
    assign revIn[gi]  = din[W-1-gi];
    assign revOut[gi] = stageOut[W-1-gi];
  end

  assign stageIn = isLeft ? revIn : din;
  assign stg[0]  = stageIn;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int D = 1 << s;
    logic [D-1:0] topBits;
    assign topBits    = isRot ? stg[s][D-1:0] : {D{fillBit}};
    assign stg[s + 1] = amt[s] ? {topBits, stg[s][W-1:D]} : stg[s];
  end

  assign stageOut = stg[SW];
  assign dout     = isLeft ? revOut : stageOut;

  always_comb begin
    if (!$isunknown({din, kind, amt})) begin
      assert_zero_amount_R10: assert (amt != '0 || dout == din)
        else $error("zero distance altered operand");
      assert_rotate_keeps_ones_R9: assert (kind != SH_ROTR || $countones(dout) == $countones(din))
        else $error("rotate changed population count");
      assert_arith_sign_R9: assert (kind != SH_ARIGHT || dout[W-1] == din[W-1])
        else $error("arithmetic shift lost sign");
      assert_left_low_zero_R9: assert (kind != SH_LEFT || amt == '0 || dout[0] == 1'b0)
        else $error("left shift did not zero-fill");
    end
  end

endmodule

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             regAmtFlag,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl              = '0;
    ctrl.aluOp        = ALU_PASS;
    ctrl.shiftKind    = SH_LEFT;
    ctrl.wrEn         = 1'b1;
    ctrl.immShifted   = opcode[0];
    ctrl.shiftFromReg = regAmtFlag;
    unique case (opcode)
      5'd0, 5'd1:  begin ctrl.aluOp = ALU_ADD;  ctrl.useImm = 1'b1; end
      5'd2, 5'd3:  begin ctrl.aluOp = ALU_OR;   ctrl.useImm = 1'b1; end
      5'd4, 5'd5:  begin ctrl.aluOp = ALU_AND;  ctrl.useImm = 1'b1; end
      5'd6, 5'd7:  begin ctrl.aluOp = ALU_PASS; ctrl.useImm = 1'b1; end
      5'd8:        ctrl.aluOp = ALU_ADD;
      5'd9:        ctrl.aluOp = ALU_SUB;
      5'd10:       ctrl.aluOp = ALU_NOT;
      5'd11:       ctrl.aluOp = ALU_NEG;
      5'd12:       ctrl.aluOp = ALU_OR;
      5'd13:       ctrl.aluOp = ALU_AND;
      5'd14:       ctrl.aluOp = ALU_XOR;
      5'd15:       begin ctrl.aluOp = ALU_SHIFT; ctrl.shiftKind = SH_ARIGHT; end
      5'd16:       begin ctrl.aluOp = ALU_SHIFT; ctrl.shiftKind = SH_LRIGHT; end
      5'd17:       begin ctrl.aluOp = ALU_SHIFT; ctrl.shiftKind = SH_LEFT;   end
      5'd18:       begin ctrl.aluOp = ALU_SHIFT; ctrl.shiftKind = SH_ROTR;   end
      default:     ctrl.wrEn = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown(opcode)) begin
      assert_write_range_R1: assert (ctrl.wrEn == (int'(opcode) <= LAST_WRITING))
        else $error("write strobe outside opcode range");
      assert_imm_only_low_R2: assert (!ctrl.useImm || opcode < 5'd8)
        else $error("immediate selected for register opcode");
    end
  end

endmodule

// File: rtl/exec_dpath.sv
module exec_dpath
  import exec_pkg::*;
#(
  parameter int W      = 32,
  parameter int LIMM_W = 17,
  parameter int SIMM_W = 10,
  localparam int SW      = $clog2(W),
  localparam int MODE_LO = SW,
  localparam int SIMM_LO = SW + 2
) (
  input  ctrl_t             ctrl,
  input  logic [LIMM_W-1:0] immField,
  input  logic [W-1:0]      rbVal,
  input  logic [W-1:0]      rcVal,
  output logic [W-1:0]      result
);

  logic [W-1:0]  immLong;
  logic [W-1:0]  immShortExt;
  logic [W-1:0]  immShaped;
  logic [W-1:0]  immFinal;
  logic [W-1:0]  opB;
  logic [W-1:0]  shOut;
  logic [SW-1:0] regDist;
  logic [W-1:0]  aluRes;
  shiftKind_e    immMode;

  assign immLong     = {{(W-LIMM_W){immField[LIMM_W-1]}}, immField};
  assign immShortExt = {{(W-SIMM_W){immField[SIMM_LO+SIMM_W-1]}},
                        immField[SIMM_LO+SIMM_W-1:SIMM_LO]};
  assign immMode     = shiftKind_e'(immField[MODE_LO+1:MODE_LO]);

  exec_shifter #(.W(W)) u_immShifter (
    .din  (immShortExt),
    .kind (immMode),
    .amt  (immField[SW-1:0]),
    .dout (immShaped)
  );

  assign immFinal = ctrl.immShifted ? immShaped : immLong;
  assign opB      = ctrl.useImm ? immFinal : rcVal;
  assign regDist  = ctrl.shiftFromReg ? rcVal[SW-1:0] : immField[SW-1:0];

  exec_shifter #(.W(W)) u_regShifter (
    .din  (rbVal),
    .kind (ctrl.shiftKind),
    .amt  (regDist),
    .dout (shOut)
  );

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD:   aluRes = rbVal + opB;
      ALU_SUB:   aluRes = rbVal - opB;
      ALU_OR:    aluRes = rbVal | opB;
      ALU_AND:   aluRes = rbVal & opB;
      ALU_XOR:   aluRes = rbVal ^ opB;
      ALU_NOT:   aluRes = ~opB;
      ALU_NEG:   aluRes = '0 - opB;
      ALU_PASS:  aluRes = opB;
      ALU_SHIFT: aluRes = shOut;
      default:   aluRes = '0;
    endcase
  end

  assign result = ctrl.wrEn ? aluRes : '0;

  always_comb begin
    if (!$isunknown({ctrl, immField, rbVal, rcVal}) && ctrl.wrEn) begin
      assert_sub_inverse_R5: assert (ctrl.aluOp != ALU_SUB || W'(result + rcVal) == rbVal)
        else $error("difference does not restore minuend");
      assert_neg_sums_zero_R6: assert (ctrl.aluOp != ALU_NEG || W'(result + rcVal) == W'(0))
        else $error("negation does not cancel");
      assert_not_disjoint_R6: assert (ctrl.aluOp != ALU_NOT || (result & rcVal) == W'(0))
        else $error("inversion shares bits with source");
    end
  end

endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int W      = 32,
  parameter int LIMM_W = 17,
  parameter int SIMM_W = 10
) (
  input  logic [OPC_W-1:0]  opcode,
  input  logic [LIMM_W-1:0] immField,
  input  logic [W-1:0]      rbVal,
  input  logic [W-1:0]      rcVal,
  output logic [W-1:0]      result,
  output logic              wrEn
);

  localparam int SW = $clog2(W);

  ctrl_t ctrl;

  exec_ctrl u_ctrl (
    .opcode     (opcode),
    .regAmtFlag (immField[SW]),
    .ctrl       (ctrl)
  );

  exec_dpath #(.W(W), .LIMM_W(LIMM_W), .SIMM_W(SIMM_W)) u_dpath (
    .ctrl     (ctrl),
    .immField (immField),
    .rbVal    (rbVal),
    .rcVal    (rcVal),
    .result   (result)
  );

  assign wrEn = ctrl.wrEn;

endmodule

// File: tb/exec_unit_bench.sv
module exec_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  opcode;
  logic [16:0] immField;
  logic [31:0] rbVal;
  logic [31:0] rcVal;
  logic [31:0] result;
  logic        wrEn;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  exec_unit u_exec_unit (
    .opcode   (opcode),
    .immField (immField),
    .rbVal    (rbVal),
    .rcVal    (rcVal),
    .result   (result),
    .wrEn     (wrEn)
  );

  function automatic logic [31:0] shModel(logic [31:0] x, logic [1:0] k, int a);
    case (k)
      2'd0:    return x << a;
      2'd1:    return x >> a;
      2'd2:    return 32'($signed(x) >>> a);
      default: return (a == 0) ? x : ((x >> a) | (x << (32 - a)));
    endcase
  endfunction

  function automatic logic [32:0] model(logic [4:0] op, logic [16:0] f,
                                        logic [31:0] b, logic [31:0] c);
    logic [31:0] i1 = {{15{f[16]}}, f};
    logic [31:0] i2 = shModel({{22{f[16]}}, f[16:7]}, f[6:5], int'(f[4:0]));
    int          d  = f[5] ? int'(c[4:0]) : int'(f[4:0]);
    case (op)
      0:  return {1'b1, b + i1};
      1:  return {1'b1, b + i2};
      2:  return {1'b1, b | i1};
      3:  return {1'b1, b | i2};
      4:  return {1'b1, b & i1};
      5:  return {1'b1, b & i2};
      6:  return {1'b1, i1};
      7:  return {1'b1, i2};
      8:  return {1'b1, b + c};
      9:  return {1'b1, b - c};
      10: return {1'b1, ~c};
      11: return {1'b1, 32'd0 - c};
      12: return {1'b1, b | c};
      13: return {1'b1, b & c};
      14: return {1'b1, b ^ c};
      15: return {1'b1, shModel(b, 2'd2, d)};
      16: return {1'b1, shModel(b, 2'd1, d)};
      17: return {1'b1, shModel(b, 2'd0, d)};
      18: return {1'b1, shModel(b, 2'd3, d)};
      default: return 33'd0;
    endcase
  endfunction

  function automatic string reqOf(logic [4:0] op);
    if (op == 0 || op == 2 || op == 4) return "R2";
    if (op == 1 || op == 3 || op == 5) return "R3";
    if (op == 6 || op == 7)            return "R4";
    if (op == 8 || op == 9)            return "R5";
    if (op == 10 || op == 11)          return "R6";
    if (op >= 12 && op <= 14)          return "R7";
    if (op >= 15 && op <= 18)          return "R8";
    return "R1";
  endfunction

  task automatic applyAndCheck(logic [4:0] op, logic [16:0] f, logic [31:0] b,
                               logic [31:0] c, logic [32:0] exp, string req);
    @(posedge clk);
    opcode = op; immField = f; rbVal = b; rcVal = c;
    @(negedge clk);
    total++;
    if ({wrEn, result} !== exp) begin
      bad++;
      $display("FAIL %s op=%0d f=%h rb=%h rc=%h got wr=%b res=%h exp wr=%b res=%h",
               req, op, f, b, c, wrEn, result, exp[32], exp[31:0]);
    end
  endtask

  task automatic sweep(logic [4:0] op, logic [16:0] f, logic [31:0] b, logic [31:0] c);
    applyAndCheck(op, f, b, c, model(op, f, b, c), reqOf(op));
  endtask

  logic [31:0] rbPats [6];
  logic [31:0] rcPats [6];
  logic [9:0]  immPats [6];

  initial begin
    bit done = 0;
    rbPats  = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678, 32'hA5A5_0F0F};
    rcPats  = '{32'hFFFF_FFE0, 32'h0000_0001, 32'h8000_0000, 32'hDEAD_BEEF, 32'h7FFF_FFFF, 32'h0F0F_F0F0};
    immPats = '{10'h3FF, 10'h200, 10'h1FF, 10'h155, 10'h001, 10'h000};
    opcode = '0; immField = '0; rbVal = '0; rcVal = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1: idle after reset, non-writing opcode gives zero.
    applyAndCheck(5'd31, 17'h1FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 33'd0, "R1");

    // Sweep: every opcode, operand patterns, all modes and distances in both flag states.
    for (int op = 0; op < 32; op++)
      for (int p = 0; p < 6; p++)
        for (int m = 0; m < 4; m++)
          for (int a = 0; a < 32; a++)
            sweep(5'(op), {immPats[p], 2'(m), 5'(a)}, rbPats[p], rcPats[p] ^ 32'(a * 7));

    // R9: fill behaviour, directed.
    applyAndCheck(5'd15, 17'h00004, 32'h8000_0000, 32'h0, {1'b1, 32'hF800_0000}, "R9");
    applyAndCheck(5'd16, 17'h00004, 32'h8000_0000, 32'h0, {1'b1, 32'h0800_0000}, "R9");
    applyAndCheck(5'd17, 17'h0001F, 32'h0000_0003, 32'h0, {1'b1, 32'h8000_0000}, "R9");
    applyAndCheck(5'd18, 17'h00001, 32'h0000_0001, 32'h0, {1'b1, 32'h8000_0000}, "R9");
    applyAndCheck(5'd7,  {10'h3F0, 2'b10, 5'd2}, 32'h0, 32'h0, {1'b1, 32'hFFFF_FFFC}, "R9");

    // R10: zero distance keeps operand, field and register sources.
    for (int op = 15; op <= 18; op++) begin
      applyAndCheck(5'(op), 17'h1FFC0, 32'h9ABC_DEF1, 32'h1234_5660, {1'b1, 32'h9ABC_DEF1}, "R10");
      applyAndCheck(5'(op), 17'h00020, 32'h9ABC_DEF1, 32'hFFFF_FFE0, {1'b1, 32'h9ABC_DEF1}, "R10");
    end
    applyAndCheck(5'd7, {10'h2AB, 2'b11, 5'd0}, 32'h0, 32'h0, {1'b1, 32'hFFFF_FEAB}, "R10");

    // R4 and R6: rb has no effect.
    applyAndCheck(5'd6,  17'h10000, 32'h1111_1111, 32'h0, {1'b1, 32'hFFFF_0000}, "R4");
    applyAndCheck(5'd6,  17'h10000, 32'hEEEE_EEEE, 32'h0, {1'b1, 32'hFFFF_0000}, "R4");
    applyAndCheck(5'd10, 17'h0, 32'hFFFF_FFFF, 32'h0000_00FF, {1'b1, 32'hFFFF_FF00}, "R6");
    applyAndCheck(5'd11, 17'h0, 32'h1234_5678, 32'h0000_0001, {1'b1, 32'hFFFF_FFFF}, "R6");

    // R5: wraparound.
    applyAndCheck(5'd8, 17'h0, 32'hFFFF_FFFF, 32'h0000_0002, {1'b1, 32'h0000_0001}, "R5");
    applyAndCheck(5'd9, 17'h0, 32'h0000_0000, 32'h0000_0001, {1'b1, 32'hFFFF_FFFF}, "R5");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule